// File: doc/BRIEF.md
# Run-Time Configurable Serial Binary-Field Multiplier

This block multiplies two elements of GF(2^m) held in polynomial basis. The field degree m and the reduction polynomial are both inputs that can change from one operation to the next. Any m from 2 up to the elaboration parameter `MAX_DEG` can be used, so one instance serves several field sizes without being rebuilt. The multiplier operand is consumed one coefficient per clock, highest coefficient first. Each step shifts the partial product up by one position, reduces it modulo the loaded polynomial, and adds the multiplicand when the current coefficient is one.

The datapath is a row of identical one-bit slices. Each slice holds a polynomial coefficient, a multiplicand coefficient and a partial-product coefficient. A per-slice steering switch takes the partial-product bit at position m−1 off the shift path and places it on an OR chain, which broadcasts the reduction feedback to every slice. Slices at or above the active degree have their register enables held off, and so do all slices while the block is idle. A small controller accepts the start strobe, counts down the m steps and flags completion.

Top module: `gf2m_serial_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `prod` is all zeros.
- R2: For an accepted operation, `prod` equals A·B mod P(x). P(x) = x^m + Σ poly[i]·x^i for i < m: bit i of `poly` is the coefficient of x^i and the x^m term is implicit. Bit i of `a`, `b` and `prod` is the coefficient of x^i.
- R3: A start is accepted on a rising edge where `start` is 1, `busy` is 0 and `deg` is valid. `busy` is then 1 for exactly `deg` cycles, and `done` rises on the edge `deg` cycles after the accepting edge, with `busy` back at 0.
- R4: `done` is high for exactly one cycle per operation.
- R5: Once `done` has fired, `prod` keeps its value until the next accepted start, whatever `a`, `b` and `poly` do.
- R6: A `start` pulse while `busy` is 1 is ignored: the running operation keeps its timing and its result.
- R7: A start with `deg` outside 2..MAX_DEG is ignored: `busy` stays 0 and `prod` keeps its value.
- R8: Bits of `a`, `b` and `poly` at or above position m are ignored, and bits of `prod` at or above position m are always 0.
- R9: Operands and polynomial are captured at the accepting edge: changing `a`, `b` or `poly` while `busy` is 1 does not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication |
| deg | input | $clog2(MAX_DEG+1) | Field degree m for this operation |
| poly | input | MAX_DEG | Low coefficients p0..p(m−1) of the reduction polynomial |
| a | input | MAX_DEG | Multiplicand |
| b | input | MAX_DEG | Multiplier, consumed from bit m−1 down to bit 0 |
| busy | output | 1 | High while the steps are running |
| done | output | 1 | One-cycle completion pulse |
| prod | output | MAX_DEG | Product, valid from `done` until the next accepted start |

## Verification
The bench builds the block with `MAX_DEG` = 8. At that size the top degree m = M is cheap to reach, so the feedback tap at the last slice is exercised alongside the smallest field, m = 2, and every size in between. The 4-bit degree port at that size can also carry the illegal values 0, 1 and 9, which exercises the rejection of degrees above the maximum. Eight-bit operands let the directed table include known products in the byte-wide field as well as all-ones, zero and identity operands. A random loop covers all seven legal degrees with several reduction polynomials.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

   typedef enum logic {
      GFM_IDLE = 1'b0,
      GFM_RUN  = 1'b1
   } gfm_state_e;

   // width of a port able to carry every degree from 0 to max_deg
   function automatic int deg_bits(input int max_deg);
      return $clog2(max_deg + 1);
   endfunction

endpackage

// File: rtl/gfm_slice.sv
// One coefficient position of the serial datapath.
module gfm_slice (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic step_en,
   input  logic a_in,
   input  logic p_in,
   input  logic d_prev,
   input  logic fb,
   input  logic bit_j,
   input  logic tap,
   input  logic chain_in,
   output logic d_q,
   output logic d_fwd,
   output logic chain_out
);

   logic p_q;
   logic a_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_q <= 1'b0;
         a_q <= 1'b0;
         d_q <= 1'b0;
      end else if (load) begin
         p_q <= p_in;
         a_q <= a_in;
         d_q <= 1'b0;
      end else if (step_en) begin
         d_q <= d_prev ^ (fb & p_q) ^ (bit_j & a_q);
      end
   end

   // steering switch: the top active bit leaves the shift path for the feedback chain
   assign d_fwd     = tap ? 1'b0 : d_q;
   assign chain_out = chain_in | (tap & d_q);

endmodule

// File: rtl/gfm_ctrl.sv
// Step sequencer: accepts a start, holds the multiplier, counts m steps.
module gfm_ctrl
   import gfm_pkg::*;
#(
   parameter  int MAX_DEG = 16,
   localparam int DEG_W   = deg_bits(MAX_DEG),
   localparam int IDX_W   = $clog2(MAX_DEG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [DEG_W-1:0]   deg,
   input  logic [MAX_DEG-1:0] b,
   output logic               busy,
   output logic               done,
   output logic               load,
   output logic               bit_j,
   output logic [MAX_DEG-1:0] act_d,
   output logic [MAX_DEG-1:0] act_q,
   output logic [MAX_DEG-1:0] tap_q
);

   gfm_state_e         state_q;
   logic [IDX_W-1:0]   cnt_q;
   logic [MAX_DEG-1:0] b_q;
   logic [MAX_DEG-1:0] tap_d;
   logic               deg_ok;

   assign deg_ok = (deg >= DEG_W'(2)) && (deg <= DEG_W'(MAX_DEG));
   assign load   = start && (state_q == GFM_IDLE) && deg_ok;

   for (genvar i = 0; i < MAX_DEG; i++) begin : g_dec
      assign act_d[i] = (DEG_W'(i) < deg);
      assign tap_d[i] = (DEG_W'(i + 1) == deg);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= GFM_IDLE;
         cnt_q   <= '0;
         b_q     <= '0;
         act_q   <= '0;
         tap_q   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            state_q <= GFM_RUN;
            cnt_q   <= IDX_W'(deg - DEG_W'(1));
            b_q     <= b & act_d;
            act_q   <= act_d;
            tap_q   <= tap_d;
         end else if (state_q == GFM_RUN) begin
            if (cnt_q == '0) begin
               state_q <= GFM_IDLE;
               done    <= 1'b1;
            end else begin
               cnt_q <= cnt_q - IDX_W'(1);
            end
         end
      end
   end

   assign busy  = (state_q == GFM_RUN);
   assign bit_j = b_q[cnt_q];

endmodule

// File: rtl/gf2m_serial_mul.sv
// Serial GF(2^m) multiplier, degree and reduction polynomial chosen per operation.
module gf2m_serial_mul
   import gfm_pkg::*;
#(
   parameter  int MAX_DEG        = 16,
   parameter  bit GATE_ABOVE_DEG = 1'b1,
   localparam int DEG_W          = deg_bits(MAX_DEG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [DEG_W-1:0]   deg,
   input  logic [MAX_DEG-1:0] poly,
   input  logic [MAX_DEG-1:0] a,
   input  logic [MAX_DEG-1:0] b,
   output logic               busy,
   output logic               done,
   output logic [MAX_DEG-1:0] prod
);

   if (MAX_DEG < 2) begin : g_bad_max_deg
      $error("gf2m_serial_mul: MAX_DEG must be at least 2");
   end

   logic               load;
   logic               bit_j;
   logic               fb;
   logic [MAX_DEG-1:0] act_d;
   logic [MAX_DEG-1:0] act_q;
   logic [MAX_DEG-1:0] tap_q;
   logic [MAX_DEG-1:0] step_en;
   logic [MAX_DEG-1:0] d_vec;
   logic [MAX_DEG-1:0] fwd_vec;
   logic [MAX_DEG-1:0] chain_vec;
   logic [MAX_DEG-1:0] a_m;
   logic [MAX_DEG-1:0] p_m;

   gfm_ctrl #(.MAX_DEG(MAX_DEG)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .deg   (deg),
      .b     (b),
      .busy  (busy),
      .done  (done),
      .load  (load),
      .bit_j (bit_j),
      .act_d (act_d),
      .act_q (act_q),
      .tap_q (tap_q)
   );

   // operand bits above the degree never reach the slices
   assign a_m = a & act_d;
   assign p_m = poly & act_d;

   if (GATE_ABOVE_DEG) begin : g_gate_deg
      assign step_en = {MAX_DEG{busy}} & act_q;
   end else begin : g_gate_idle
      assign step_en = {MAX_DEG{busy}};
   end

   assign fb = chain_vec[MAX_DEG-1];

   for (genvar i = 0; i < MAX_DEG; i++) begin : g_slice
      logic d_prev;
      logic chain_in;
      if (i == 0) begin : g_first
         assign d_prev   = 1'b0;
         assign chain_in = 1'b0;
      end else begin : g_rest
         assign d_prev   = fwd_vec[i-1];
         assign chain_in = chain_vec[i-1];
      end
      gfm_slice u_slice (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (load),
         .step_en   (step_en[i]),
         .a_in      (a_m[i]),
         .p_in      (p_m[i]),
         .d_prev    (d_prev),
         .fb        (fb),
         .bit_j     (bit_j),
         .tap       (tap_q[i]),
         .chain_in  (chain_in),
         .d_q       (d_vec[i]),
         .d_fwd     (fwd_vec[i]),
         .chain_out (chain_vec[i])
      );
   end

   assign prod = d_vec;

endmodule

// File: rtl/gfm_mul_checker.sv
module gfm_mul_checker
   import gfm_pkg::*;
#(
   parameter  int MAX_DEG = 16,
   localparam int DEG_W   = deg_bits(MAX_DEG),
   localparam int CW      = DEG_W + 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [DEG_W-1:0]   deg,
   input logic               busy,
   input logic               done,
   input logic [MAX_DEG-1:0] prod
);

   logic             accept;
   logic [DEG_W-1:0] lat_deg;
   logic [CW-1:0]    run_cnt;

   assign accept = start && !busy && (deg >= DEG_W'(2)) && (deg <= DEG_W'(MAX_DEG));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_deg <= '0;
         run_cnt <= '0;
      end else if (accept) begin
         lat_deg <= deg;
         run_cnt <= '0;
      end else if (busy) begin
         run_cnt <= run_cnt + CW'(1);
      end
   end

   p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);

   p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_cnt == {1'b0, lat_deg}));

   p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(prod));

   p_bad_deg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !accept) |=> (!busy && $stable(prod)));

   p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ((prod >> lat_deg) == '0));

endmodule

bind gf2m_serial_mul gfm_mul_checker #(.MAX_DEG(MAX_DEG)) u_gfm_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .deg   (deg),
   .busy  (busy),
   .done  (done),
   .prod  (prod)
);

// File: tb/gf2m_serial_mul_bench.sv
`timescale 1ns/1ps
module gf2m_serial_mul_bench;

   localparam int M  = 8;
   localparam int DW = 4;
   localparam int NV = 12;

   // {deg[3:0], poly[7:0], a[7:0], b[7:0]}
   localparam logic [27:0] VEC [NV] = '{
      28'h2_03_02_03,
      28'h3_03_05_06,
      28'h4_03_0F_0F,
      28'h4_09_09_0D,
      28'h5_05_1F_11,
      28'h6_03_2A_35,
      28'h7_03_7F_40,
      28'h8_1B_57_83,
      28'h8_1D_FF_FF,
      28'h8_1B_00_A5,
      28'h8_1B_01_FF,
      28'h3_FB_F5_A6   // dirty upper bits (R8)
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [DW-1:0] deg = '0;
   logic [M-1:0]  poly = '0;
   logic [M-1:0]  a_i = '0;
   logic [M-1:0]  b_i = '0;
   logic          busy;
   logic          done;
   logic [M-1:0]  prod;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   gf2m_serial_mul #(.MAX_DEG(M)) u_gf2m_serial_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .deg   (deg),
      .poly  (poly),
      .a     (a_i),
      .b     (b_i),
      .busy  (busy),
      .done  (done),
      .prod  (prod)
   );

   function automatic logic [M-1:0] ref_mul(input int m, input logic [M-1:0] p,
                                            input logic [M-1:0] av, input logic [M-1:0] bv);
      logic [15:0] acc;
      logic [15:0] full;
      logic [M-1:0] msk;
      msk  = M'((16'd1 << m) - 16'd1);
      acc  = '0;
      for (int i = 0; i < M; i++)
         if (bv[i] && msk[i]) acc ^= 16'(av & msk) << i;
      full = 16'(p & msk) | (16'd1 << m);
      for (int i = 14; i >= m; i--)
         if (acc[i]) acc ^= full << (i - m);
      return acc[M-1:0];
   endfunction

   function automatic logic [M-1:0] poly_for(input int m);
      case (m)
         5:       return 8'h05;
         8:       return 8'h1B;
         default: return 8'h03;
      endcase
   endfunction

   task automatic check_eq(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // mode 0: plain, 1: extra start while busy (R6), 2: inputs change while busy (R9)
   task automatic run_op(input logic [3:0] d, input logic [M-1:0] p, input logic [M-1:0] av,
                         input logic [M-1:0] bv, input int mode,
                         output logic [M-1:0] res, output int lat);
      int k;
      @(negedge clk);
      deg = d; poly = p; a_i = av; b_i = bv; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k = 0;
      while (!done && k < 100) begin
         if (k == 1) begin
            check_eq("R3 busy during steps", 16'(busy), 16'd1);
            if (mode == 1) begin
               start = 1'b1; deg = 4'd3; poly = 8'h03; a_i = 8'h07; b_i = 8'h05;
            end
            if (mode == 2) begin
               poly = ~p; a_i = ~av; b_i = ~bv;
            end
         end
         if (k == 2) start = 1'b0;
         @(negedge clk);
         k++;
      end
      start = 1'b0;
      lat = k;
      res = prod;
      check_eq("R3 busy low at done", 16'(busy), 16'd0);
      @(negedge clk);
      check_eq("R4 done single cycle", 16'(done), 16'd0);
      check_eq("R5 result held", 16'(prod), 16'(res));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [M-1:0] res;
      logic [M-1:0] held;
      int           lat;

      repeat (3) @(negedge clk);
      check_eq("R1 busy after reset", 16'(busy), 16'd0);
      check_eq("R1 done after reset", 16'(done), 16'd0);
      check_eq("R1 prod after reset", 16'(prod), 16'd0);
      rst_n = 1'b1;

      // R2/R3/R8: directed table
      for (int v = 0; v < NV; v++) begin
         logic [3:0]   vd;
         logic [M-1:0] vp, va, vb;
         {vd, vp, va, vb} = VEC[v];
         run_op(vd, vp, va, vb, 0, res, lat);
         check_eq("R2 table product", 16'(res), 16'(ref_mul(int'(vd), vp, va, vb)));
         check_eq("R3 latency", 16'(lat), 16'(vd));
         check_eq("R8 upper bits zero", 16'(res >> vd), 16'd0);
      end

      // R2: random operands over every legal degree
      for (int r = 0; r < 70; r++) begin
         int           m;
         logic [M-1:0] ra, rb, rp;
         m  = 2 + (r % 7);
         rp = poly_for(m);
         ra = M'($urandom) & M'((16'd1 << m) - 16'd1);
         rb = M'($urandom) & M'((16'd1 << m) - 16'd1);
         run_op(4'(m), rp, ra, rb, 0, res, lat);
         check_eq("R2 random product", 16'(res), 16'(ref_mul(m, rp, ra, rb)));
         check_eq("R3 random latency", 16'(lat), 16'(m));
      end

      // R6: start while busy is ignored
      run_op(4'd8, 8'h1B, 8'h57, 8'h13, 1, res, lat);
      check_eq("R6 result unchanged", 16'(res), 16'(ref_mul(8, 8'h1B, 8'h57, 8'h13)));
      check_eq("R6 latency unchanged", 16'(lat), 16'd8);

      // R9: operand changes while busy are ignored
      run_op(4'd2, 8'h03, 8'h02, 8'h02, 2, res, lat);
      check_eq("R9 m=2 inputs captured", 16'(res), 16'(ref_mul(2, 8'h03, 8'h02, 8'h02)));
      run_op(4'd6, 8'h03, 8'h2D, 8'h1B, 2, res, lat);
      check_eq("R9 m=6 inputs captured", 16'(res), 16'(ref_mul(6, 8'h03, 8'h2D, 8'h1B)));

      // R5: long idle with moving inputs
      held = prod;
      repeat (6) begin
         @(negedge clk);
         a_i = M'($urandom); b_i = M'($urandom); poly = M'($urandom);
      end
      @(negedge clk);
      check_eq("R5 idle hold", 16'(prod), 16'(held));

      // R7: illegal degrees
      for (int t = 0; t < 3; t++) begin
         logic [3:0] bd;
         bd = (t == 0) ? 4'd0 : (t == 1) ? 4'd1 : 4'd9;
         @(negedge clk);
         deg = bd; poly = 8'h03; a_i = 8'h05; b_i = 8'h07; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         check_eq("R7 busy stays low", 16'(busy), 16'd0);
         @(negedge clk);
         check_eq("R7 prod unchanged", 16'(prod), 16'(held));
      end

      // recovery after rejected starts
      run_op(4'd8, 8'h1B, 8'hCA, 8'h53, 0, res, lat);
      check_eq("R2 after rejects", 16'(res), 16'(ref_mul(8, 8'h1B, 8'hCA, 8'h53)));

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule